// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the trigger sequencer of an on-chip debug unit. Three comparator channels, numbered 0 to 2, each raise a one-cycle match pulse. The sequencer counts a pulse only when the enable bit for that channel is set. Once the block is armed it walks from State1 to State2 and then to State3. From State3 it can go on to the Final state, or it can fall back to State1 or State2. Final raises a sticky flag, which tells the debug logic that the whole trigger sequence has been satisfied.

The exit from State3 is set by a 4-bit selection code. Some codes route a single channel. Some route two channels to different destinations. Two codes treat channels 1 and 2 as one group. Five codes are reserved and cause no transitions. When several enabled matches arrive in the same cycle, a match that leads to Final wins. Failing that, the lowest-numbered channel that has an effect wins. State1 and State2 are simplified: any enabled match moves them on to the next numbered state.

Software programs three banked selection registers through a small write/read port. The port has a 2-bit bank field, and a write is refused while the sequencer is armed.

Top module: `dbg_seq_top`

## Requirements
- R1: While rst_ni is low, state_o is 0 (idle), final_o is 0, and all three selection registers read back zero.
- R2: The read data depends on bank_i. Banks 2'b00, 2'b01 and 2'b10 return the State1, State2 and State3 codes in bits 3:0, with bits 7:4 always zero. Bank 2'b11 reads 8'h00. The read is combinational from bank_i.
- R3: A write stores wdata_i[3:0] into the addressed bank at the clock edge. It takes effect only when the sequencer is not armed (state_o is 0 or 4). A write made while armed leaves every register unchanged.
- R4: arm_i high while not armed moves state_o to 1 (State1) on the next edge and clears final_o. arm_i high while armed has no effect.
- R5: A match pulse on a channel whose cmp_en_i bit is 0 has no effect in any state.
- R6: In State1 (state_o=1), any enabled match moves the sequencer to State2 (2) on the next edge. In State2, any enabled match moves it to State3 (3).
- R7: In State3 the single-route codes act as follows: 0000 sends ch0 to State1, 0100 sends ch1 to State2, 0101 sends ch1 to Final, and 0111 sends ch0 to Final.
- R8: In State3 the two-route codes act as follows:
  - 0001 sends ch2 to State2 and ch1 to Final.
  - 0010 sends ch0 to Final and ch1 to State1.
  - 0011 sends ch1 to Final and ch2 to State1.
  - 0110 sends ch2 to State2 and ch0 to Final.
  - 1110 sends ch0 to State2 and ch2 to Final.
- R9: In State3 the grouped codes act as follows. Code 1010 sends ch1 or ch2 to State1 and ch0 to Final. Code 1101 sends ch1 or ch2 to Final and ch0 to State1.
- R10: In State3, a match that the code does not name leaves the state unchanged. The reserved codes 1000, 1001, 1011, 1100 and 1111 leave it unchanged for every match.
- R11: When enabled matches arrive in State3 in the same cycle, a Final-bound match wins. Otherwise the lowest-numbered channel with an effect wins.
- R12: Entering Final sets state_o to 4 and final_o to 1. Both hold, whatever the matches do, until arm_i starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| bank_i | input | 2 | Bank select for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected bank |
| arm_i | input | 1 | Start a new sequence from State1 |
| match_i | input | 3 | Per-channel comparator match pulses |
| cmp_en_i | input | 3 | Per-channel comparator enables |
| state_o | output | 3 | 0 idle, 1 State1, 2 State2, 3 State3, 4 Final |
| final_o | output | 1 | Sticky final-state flag |

## Verification
The checker treats every input as synchronous to clk_i and settled before each rising edge, and it treats match_i as meaningful only where cmp_en_i is set. It also assumes that the State3 code changes only through the write port. The bench changes every input just after a falling edge and holds it through the next rising edge. It sweeps all sixteen codes against all seven non-empty match patterns in State3. Writes and arm pulses are issued both while armed and while disarmed, so that the lock and the ignored-arm paths are both exercised.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int NUM_CH    = 3;
  localparam int CODE_W    = 4;
  localparam int REG_W     = 8;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 3;
  localparam int ST_W      = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_S1    = 3'd1,
    ST_S2    = 3'd2,
    ST_S3    = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_S1   = 2'd1,
    DST_S2   = 2'd2,
    DST_FIN  = 2'd3
  } dest_e;
endpackage

// File: rtl/dbg_seq_regs.sv
module dbg_seq_regs
  import dbg_seq_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int RW = REG_W,
  parameter int BW = BANK_W,
  parameter int NB = NUM_BANKS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 lock_i,
  input  logic [BW-1:0]        bank_i,
  input  logic [RW-1:0]        wdata_i,
  output logic [RW-1:0]        rdata_o,
  output logic [NB-1:0][CW-1:0] code_o
);
  localparam int PAD_W = RW - CW;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = we_i && !lock_i && (bank_i == BW'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  code_o[b] <= '0;
      else if (hit) code_o[b] <= wdata_i[CW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank_i == BW'(b)) rdata_o = {{PAD_W{1'b0}}, code_o[b]};
    end
  end
endmodule

// File: rtl/dbg_seq_s3_decode.sv
module dbg_seq_s3_decode
  import dbg_seq_pkg::*;
(
  input  logic [CODE_W-1:0]        code_i,
  output logic [NUM_CH-1:0][1:0]   dst_o
);
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) dst_o[c] = DST_NONE;
    case (code_i)
      4'b0000: dst_o[0] = DST_S1;
      4'b0001: begin dst_o[2] = DST_S2;  dst_o[1] = DST_FIN; end
      4'b0010: begin dst_o[0] = DST_FIN; dst_o[1] = DST_S1;  end
      4'b0011: begin dst_o[1] = DST_FIN; dst_o[2] = DST_S1;  end
      4'b0100: dst_o[1] = DST_S2;
      4'b0101: dst_o[1] = DST_FIN;
      4'b0110: begin dst_o[2] = DST_S2;  dst_o[0] = DST_FIN; end
      4'b0111: dst_o[0] = DST_FIN;
      4'b1010: begin dst_o[1] = DST_S1;  dst_o[2] = DST_S1;  dst_o[0] = DST_FIN; end
      4'b1101: begin dst_o[1] = DST_FIN; dst_o[2] = DST_FIN; dst_o[0] = DST_S1;  end
      4'b1110: begin dst_o[0] = DST_S2;  dst_o[2] = DST_FIN; end
      default: ; // reserved: no routes
    endcase
  end
endmodule

// File: rtl/dbg_seq_resolve.sv
module dbg_seq_resolve
  import dbg_seq_pkg::*;
(
  input  logic [NUM_CH-1:0]      hit_i,
  input  logic [NUM_CH-1:0][1:0] dst_i,
  output logic [1:0]             sel_o
);
  logic [NUM_CH-1:0] fin_hit;
  logic [NUM_CH-1:0] act_hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign act_hit[c] = hit_i[c] && (dst_i[c] != DST_NONE);
    assign fin_hit[c] = hit_i[c] && (dst_i[c] == DST_FIN);
  end

  // Final-bound first, then lowest channel with an effect.
  always_comb begin
    sel_o = DST_NONE;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (act_hit[c]) sel_o = dst_i[c];
    end
    if (|fin_hit) sel_o = DST_FIN;
  end
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic [1:0]        s3_sel_i,
  output logic [ST_W-1:0]   state_o,
  output logic              final_o,
  output logic              armed_o
);
  seq_state_e state_q, state_d;
  logic       final_q, final_d;

  assign armed_o = (state_q == ST_S1) || (state_q == ST_S2) || (state_q == ST_S3);

  always_comb begin
    state_d = state_q;
    final_d = final_q;
    case (state_q)
      ST_IDLE, ST_FINAL: begin
        if (arm_i) begin
          state_d = ST_S1;
          final_d = 1'b0;
        end
      end
      ST_S1: if (|hit_i) state_d = ST_S2;
      ST_S2: if (|hit_i) state_d = ST_S3;
      ST_S3: begin
        case (s3_sel_i)
          DST_S1:  state_d = ST_S1;
          DST_S2:  state_d = ST_S2;
          DST_FIN: begin
            state_d = ST_FINAL;
            final_d = 1'b1;
          end
          default: ;
        endcase
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      final_q <= 1'b0;
    end else begin
      state_q <= state_d;
      final_q <= final_d;
    end
  end

  assign state_o = state_q;
  assign final_o = final_q;
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              arm_i,
  input  logic [NUM_CH-1:0] match_i,
  input  logic [NUM_CH-1:0] cmp_en_i,
  output logic [ST_W-1:0]   state_o,
  output logic              final_o
);
  localparam int S3_BANK = 2;

  logic [NUM_BANKS-1:0][CODE_W-1:0] codes;
  logic [CODE_W-1:0]                code_s3;
  logic [NUM_CH-1:0][1:0]           s3_dst;
  logic [1:0]                       s3_sel;
  logic [NUM_CH-1:0]                hit;
  logic                             armed;

  assign hit     = match_i & cmp_en_i;
  assign code_s3 = codes[S3_BANK];

  dbg_seq_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .lock_i  (armed),
    .bank_i  (bank_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .code_o  (codes)
  );

  dbg_seq_s3_decode i_dec (
    .code_i (code_s3),
    .dst_o  (s3_dst)
  );

  dbg_seq_resolve i_res (
    .hit_i (hit),
    .dst_i (s3_dst),
    .sel_o (s3_sel)
  );

  dbg_seq_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .hit_i    (hit),
    .s3_sel_i (s3_sel),
    .state_o  (state_o),
    .final_o  (final_o),
    .armed_o  (armed)
  );
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk
  import dbg_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic [NUM_CH-1:0] match_i,
  input logic [NUM_CH-1:0] cmp_en_i,
  input logic [ST_W-1:0]   state_o,
  input logic              final_o,
  input logic [REG_W-1:0]  rdata_o,
  input logic [CODE_W-1:0] code_s3
);
  logic armed;
  logic s3_reserved;
  assign armed = (state_o == 3'd1) || (state_o == 3'd2) || (state_o == 3'd3);
  assign s3_reserved = (code_s3 == 4'b1000) || (code_s3 == 4'b1001) ||
                       (code_s3 == 4'b1011) || (code_s3 == 4'b1100) ||
                       (code_s3 == 4'b1111);

  assert_rdata_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:CODE_W] == '0);

  assert_write_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> $stable(code_s3));

  assert_arm_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && arm_i) |=> (state_o == 3'd1 && !final_o));

  assert_disabled_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ((match_i & cmp_en_i) == '0)) |=> $stable(state_o));

  assert_s1_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && |(match_i & cmp_en_i)) |=> state_o == 3'd2);

  assert_s2_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && |(match_i & cmp_en_i)) |=> state_o == 3'd3);

  assert_reserved_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && s3_reserved) |=> state_o == 3'd3);

  assert_final_first_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && code_s3 == 4'b0001 && (match_i & cmp_en_i & 3'b110) == 3'b110)
    |=> state_o == 3'd4);

  assert_final_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !arm_i) |=> (state_o == 3'd4 && final_o));

  assert_final_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    final_o == (state_o == 3'd4));
endmodule

bind dbg_seq_top dbg_seq_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .arm_i    (arm_i),
  .match_i  (match_i),
  .cmp_en_i (cmp_en_i),
  .state_o  (state_o),
  .final_o  (final_o),
  .rdata_o  (rdata_o),
  .code_s3  (code_s3)
);

// File: tb/test_dbg_seq_top.sv
module test_dbg_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] bank_i = 2'b00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       arm_i = 1'b0;
  logic [2:0] match_i = 3'b000;
  logic [2:0] cmp_en_i = 3'b000;
  logic [2:0] state_o;
  logic       final_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int         m_state = 0;
  bit         m_fin = 1'b0;
  logic [3:0] m_code [3];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dbg_seq_top i_dbg_seq_top (
    .clk_i, .rst_ni, .we_i, .bank_i, .wdata_i, .rdata_o,
    .arm_i, .match_i, .cmp_en_i, .state_o, .final_o
  );

  // 0 none, 1 State1, 2 State2, 3 Final
  function automatic int route(input logic [3:0] code, input int ch);
    int r = 0;
    case (ch)
      0: begin
        if (code == 4'h0 || code == 4'hD) r = 1;
        else if (code == 4'hE) r = 2;
        else if (code inside {4'h2, 4'h6, 4'h7, 4'hA}) r = 3;
      end
      1: begin
        if (code inside {4'h2, 4'hA}) r = 1;
        else if (code == 4'h4) r = 2;
        else if (code inside {4'h1, 4'h3, 4'h5, 4'hD}) r = 3;
      end
      default: begin
        if (code inside {4'h3, 4'hA}) r = 1;
        else if (code inside {4'h1, 4'h6}) r = 2;
        else if (code inside {4'hD, 4'hE}) r = 3;
      end
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [7:0] exp_rd;
    exp_rd = (bank_i < 2'd3) ? {4'b0, m_code[bank_i]} : 8'h00;
    check(state_o === 3'(m_state), tag, "state_o", int'(state_o), m_state);
    check(final_o === m_fin, tag, "final_o", int'(final_o), int'(m_fin));
    check(rdata_o === exp_rd, tag, "rdata_o", int'(rdata_o), int'(exp_rd));
  endtask

  task automatic model_edge();
    bit armed;
    bit to_fin;
    int pick;
    logic [2:0] hits;
    armed = (m_state >= 1 && m_state <= 3);
    hits = match_i & cmp_en_i;
    if (we_i && !armed && bank_i < 2'd3) m_code[bank_i] = wdata_i[3:0];
    if (!armed) begin
      if (arm_i) begin m_state = 1; m_fin = 1'b0; end
    end else if (m_state == 1) begin
      if (hits != 0) m_state = 2;
    end else if (m_state == 2) begin
      if (hits != 0) m_state = 3;
    end else begin
      to_fin = 1'b0;
      pick = 0;
      for (int c = 2; c >= 0; c--) begin
        if (hits[c] && route(m_code[2], c) != 0) pick = route(m_code[2], c);
        if (hits[c] && route(m_code[2], c) == 3) to_fin = 1'b1;
      end
      if (to_fin) begin m_state = 4; m_fin = 1'b1; end
      else if (pick != 0) m_state = pick;
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] bank, input logic [7:0] wd,
                     input logic arm, input logic [2:0] m, input logic [2:0] en,
                     input string tag);
    we_i = we; bank_i = bank; wdata_i = wd; arm_i = arm; match_i = m; cmp_en_i = en;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic do_reset();
    we_i = 1'b0; arm_i = 1'b0; match_i = '0; cmp_en_i = '0;
    rst_ni = 1'b0;
    #1;
    m_state = 0; m_fin = 1'b0;
    for (int b = 0; b < 3; b++) m_code[b] = 4'h0;
    for (int b = 0; b < 4; b++) begin
      bank_i = 2'(b);
      #1;
      compare("R1");
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // Reach State3 with a given code, then apply one match pattern.
  task automatic s3_case(input logic [3:0] code, input logic [2:0] m,
                         input logic [2:0] en, input string tag);
    do_reset();
    cyc(1'b1, 2'b10, {4'hA, code}, 1'b0, 3'b000, 3'b000, "R3");
    cyc(1'b0, 2'b10, 8'h00, 1'b1, 3'b000, 3'b000, "R4");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b100, 3'b111, "R6");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b001, 3'b111, "R6");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, m, en, tag);
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b000, 3'b111, tag);
  endtask

  initial begin
    for (int b = 0; b < 3; b++) m_code[b] = 4'h0;
    @(negedge clk_i);
    do_reset();

    // R2/R3: banked writes and reads while disarmed
    cyc(1'b1, 2'b00, 8'hF5, 1'b0, 3'b000, 3'b000, "R3");
    cyc(1'b1, 2'b01, 8'h3C, 1'b0, 3'b000, 3'b000, "R3");
    cyc(1'b1, 2'b11, 8'hFF, 1'b0, 3'b000, 3'b000, "R2");
    cyc(1'b0, 2'b00, 8'h00, 1'b0, 3'b000, 3'b000, "R2");
    cyc(1'b0, 2'b01, 8'h00, 1'b0, 3'b000, 3'b000, "R2");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b000, 3'b000, "R2");

    // R5: enabled-off matches are ignored in State1
    cyc(1'b0, 2'b10, 8'h00, 1'b1, 3'b000, 3'b000, "R4");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b111, 3'b000, "R5");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b010, 3'b101, "R5");
    // R3: writes while armed are refused
    cyc(1'b1, 2'b10, 8'h07, 1'b0, 3'b000, 3'b000, "R3");
    cyc(1'b1, 2'b00, 8'h09, 1'b0, 3'b000, 3'b000, "R3");
    cyc(1'b0, 2'b00, 8'h00, 1'b0, 3'b000, 3'b000, "R3");
    // R4: arm while armed does nothing
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b010, 3'b010, "R6");
    cyc(1'b0, 2'b10, 8'h00, 1'b1, 3'b000, 3'b000, "R4");

    // R7-R10: every code with every single-channel match
    for (int code = 0; code < 16; code++) begin
      for (int ch = 0; ch < 3; ch++) begin
        s3_case(4'(code), 3'(1 << ch), 3'b111, "R7_R8_R9_R10");
      end
    end

    // R11: every code with every multi-channel pattern
    for (int code = 0; code < 16; code++) begin
      for (int m = 3; m < 8; m++) begin
        if (m != 4) s3_case(4'(code), 3'(m), 3'b111, "R11");
      end
    end

    // R5 in State3: a Final-bound channel masked off
    s3_case(4'h7, 3'b001, 3'b110, "R5");
    s3_case(4'h1, 3'b110, 3'b100, "R5");

    // R12: Final holds, then R4 rearm clears the flag
    s3_case(4'h5, 3'b010, 3'b111, "R12");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b111, 3'b111, "R12");
    cyc(1'b1, 2'b10, 8'h0E, 1'b0, 3'b000, 3'b000, "R3");
    cyc(1'b0, 2'b10, 8'h00, 1'b1, 3'b000, 3'b000, "R4");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b001, 3'b001, "R6");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b001, 3'b001, "R6");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b101, 3'b111, "R11");
    cyc(1'b0, 2'b10, 8'h00, 1'b0, 3'b000, 3'b000, "R12");

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule